// File: doc/BRIEF.md
# Fault Response and Event Logger

This block sits between the protection comparators and monitors of a digitally controlled power supply and the power stage enables. Seven fault inputs arrive as levels: short-circuit, over-voltage, over-current, watchdog timeout, over-temperature, fan failure and communication error. Each source carries a host-programmed response policy. The block resolves these policies into a PWM-enable line and a derate line. The possible responses are a controlled shutdown that lasts while the fault is present, a hiccup restart with a bounded retry budget, a latch-off, and a derate request that leaves the output running.

The block logs each new fault occurrence into a ring of records. A record holds a free-running cycle timestamp, the source code and a snapshot of the telemetry bus. Each logged record raises an alert line, which stays up until the host acknowledges it. The host reads the oldest unread record at a head port and consumes it with a pop strobe. The head position and the number of unread records are visible to the host at all times.

Top module: `frl_top`

## Requirements
- R1: After reset, pwmEnable is 1, derate, latched and alert are 0, and unreadCount is 0.
- R2: A source is logged once per low-to-high transition of its input. An input held high produces no further records.
- R3: A record holds the value of a timestamp counter that advances by one every clock, the source index (0 short-circuit, 1 over-voltage, 2 over-current, 3 watchdog, 4 over-temperature, 5 fan, 6 communication) and the telemetry input sampled in the cycle the record is written. The record of a rise seen at a clock edge is written at that same edge.
- R4: When several sources rise in the same cycle, one record is written per cycle, lowest source index first.
- R5: When DEPTH records are unread and a new one is written without a pop, the oldest record is discarded and unreadCount stays at DEPTH.
- R6: A pop with unreadCount above zero advances the head to the next older-to-newer record and lowers unreadCount by one. A pop with no unread records has no effect.
- R7: alert rises on every record write and stays high until alertAck. A write in the same cycle as alertAck leaves alert high.
- R8: The policy of source i is policyCfg[2i+1:2i], encoded as 0 derate, 1 shutdown, 2 hiccup and 3 latch. A shutdown-policy source holds pwmEnable at 0 for as long as its input is high.
- R9: derate is 1 while any derate-policy input is high, but only while pwmEnable is 1.
- R10: A hiccup-policy rise holds pwmEnable at 0 for exactly hiccupOff cycles, after which PWM is re-enabled.
- R11: A hiccup-policy rise that arrives when retryLimit restarts have already occurred, with no intervening run of hiccupOff quiet enabled cycles, escalates to latch-off.
- R12: latched holds pwmEnable at 0 until clearLatch. The watchdog source (index 3) always latches, whatever its programmed policy.
- R13: When a latch event and a hiccup event occur in the same cycle, only the latch takes effect. After clearLatch, PWM returns at once with no hiccup off-time pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultIn | input | NSRC | Fault levels, one per source |
| policyCfg | input | 2*NSRC | Response policy, two bits per source |
| hiccupOff | input | OFF_W | Hiccup off-time and quiet window in cycles |
| retryLimit | input | RETRY_W | Hiccup restarts allowed before latch-off |
| telemetry | input | NTEL*TEL_W | Telemetry snapshot bus |
| clearLatch | input | 1 | Host clear of latch-off and hiccup state |
| alertAck | input | 1 | Host acknowledge of alert |
| rdPop | input | 1 | Consume the head record |
| pwmEnable | output | 1 | Power stage enable |
| derate | output | 1 | Reduced-limit request |
| latched | output | 1 | Latch-off active |
| alert | output | 1 | New record pending attention |
| rdTs | output | TS_W | Head record timestamp |
| rdSrc | output | SRC_W | Head record source index |
| rdSnap | output | NTEL*TEL_W | Head record telemetry snapshot |
| rdPtr | output | PTR_W | Head slot index |
| unreadCount | output | CNT_W | Number of unread records |

## Verification
Two sets of events can fall in the same cycle. The first is a latch event and a hiccup event. The second is a record write and the host's acknowledge or pop. The bench raises the short-circuit and over-current inputs on the same clock and expects only a latch. After clearLatch it expects PWM back in the next cycle, which shows that no hiccup timer was started. It also drives alertAck in the cycle a new fault is logged and expects alert to stay high. Two simultaneous rises are judged by the record count one and two cycles later and by the order of source codes at the head.

// File: rtl/frl_pkg.sv
package frl_pkg;
  typedef enum logic [1:0] {
    POL_DERATE = 2'd0,
    POL_SHUT   = 2'd1,
    POL_HICCUP = 2'd2,
    POL_LATCH  = 2'd3
  } policy_e;

  typedef struct packed {
    logic wrEn;
    logic popEn;
  } logStrobe_t;
endpackage

// File: rtl/frl_ctrl.sv
module frl_ctrl
  import frl_pkg::*;
#(
  parameter int NSRC     = 7,
  parameter int SRC_W    = 3,
  parameter int OFF_W    = 12,
  parameter int RETRY_W  = 3,
  parameter int WDOG_IDX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   faultIn,
  input  logic [2*NSRC-1:0] policyCfg,
  input  logic [OFF_W-1:0]  hiccupOff,
  input  logic [RETRY_W-1:0] retryLimit,
  input  logic              clearLatch,
  input  logic              alertAck,
  input  logic              rdPop,
  input  logic              logNotEmpty,
  output logStrobe_t        strobe,
  output logic [SRC_W-1:0]  srcCode,
  output logic              pwmEnable,
  output logic              derate,
  output logic              latched,
  output logic              alert
);
  logic [NSRC-1:0] faultPrev, pendQ, rise, sel, pickOh;
  logic [NSRC-1:0] latchMask, hicMask, shutMask, derMask;
  logic            latchedQ, alertQ;
  logic [OFF_W-1:0]   offCnt, quietCnt;
  logic [RETRY_W-1:0] retryCnt;
  logic latchEv, hicEv, goLatch, goHic;

  for (genvar g = 0; g < NSRC; g++) begin : gPol
    logic [1:0] pol;
    assign pol          = (g == WDOG_IDX) ? POL_LATCH : policyCfg[2*g +: 2];
    assign latchMask[g] = (pol == POL_LATCH);
    assign hicMask[g]   = (pol == POL_HICCUP);
    assign shutMask[g]  = (pol == POL_SHUT);
    assign derMask[g]   = (pol == POL_DERATE);
  end

  assign rise = faultIn & ~faultPrev;
  assign sel  = pendQ | rise;

  // lowest index wins the single write slot of this cycle
  always_comb begin
    pickOh  = '0;
    srcCode = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (sel[i]) begin
        pickOh    = '0;
        pickOh[i] = 1'b1;
        srcCode   = SRC_W'(i);
      end
    end
  end

  assign latchEv = |(rise & latchMask);
  assign hicEv   = |(rise & hicMask);
  assign goLatch = latchEv || (hicEv && (retryCnt >= retryLimit));
  assign goHic   = hicEv && !goLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultPrev <= '0;
      pendQ     <= '0;
      latchedQ  <= 1'b0;
      alertQ    <= 1'b0;
      offCnt    <= '0;
      quietCnt  <= '0;
      retryCnt  <= '0;
    end else begin
      faultPrev <= faultIn;
      pendQ     <= sel & ~pickOh;

      if (goLatch)         latchedQ <= 1'b1;
      else if (clearLatch) latchedQ <= 1'b0;

      if (|sel)          alertQ <= 1'b1;
      else if (alertAck) alertQ <= 1'b0;

      if (goLatch || clearLatch) begin
        offCnt   <= '0;
        retryCnt <= '0;
        quietCnt <= '0;
      end else if (goHic) begin
        offCnt   <= hiccupOff;
        retryCnt <= retryCnt + RETRY_W'(1);
        quietCnt <= '0;
      end else if (offCnt != '0) begin
        offCnt <= offCnt - OFF_W'(1);
      end else if (retryCnt != '0) begin
        if (quietCnt == hiccupOff) begin
          retryCnt <= '0;
          quietCnt <= '0;
        end else begin
          quietCnt <= quietCnt + OFF_W'(1);
        end
      end
    end
  end

  assign strobe.wrEn  = |sel;
  assign strobe.popEn = rdPop && logNotEmpty;
  assign latched      = latchedQ;
  assign alert        = alertQ;
  assign pwmEnable    = !latchedQ && (offCnt == '0) && !(|(faultIn & shutMask));
  assign derate       = pwmEnable && |(faultIn & derMask);
endmodule

// File: rtl/frl_log.sv
module frl_log
  import frl_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TS_W   = 16,
  parameter int SRC_W  = 3,
  parameter int SNAP_W = 36,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobe_t        strobe,
  input  logic [SRC_W-1:0]  srcCode,
  input  logic [SNAP_W-1:0] snapIn,
  output logic [TS_W-1:0]   rdTs,
  output logic [SRC_W-1:0]  rdSrc,
  output logic [SNAP_W-1:0] rdSnap,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [CNT_W-1:0]  unreadCount,
  output logic              notEmpty
);
  logic [TS_W-1:0]   tsMem   [DEPTH];
  logic [SRC_W-1:0]  srcMem  [DEPTH];
  logic [SNAP_W-1:0] snapMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, headPtr;
  logic [CNT_W-1:0]  cnt;
  logic [TS_W-1:0]   tsCnt;
  logic full, drop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full = (cnt == CNT_W'(DEPTH));
  assign drop = strobe.wrEn && full && !strobe.popEn;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tsMem[wrPtr]   <= tsCnt;
      srcMem[wrPtr]  <= srcCode;
      snapMem[wrPtr] <= snapIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      headPtr <= '0;
      cnt     <= '0;
      tsCnt   <= '0;
    end else begin
      tsCnt <= tsCnt + TS_W'(1);
      if (strobe.wrEn) wrPtr <= nextPtr(wrPtr);
      if (strobe.popEn || drop) headPtr <= nextPtr(headPtr);
      if (strobe.wrEn && !strobe.popEn && !full) cnt <= cnt + CNT_W'(1);
      else if (!strobe.wrEn && strobe.popEn)     cnt <= cnt - CNT_W'(1);
    end
  end

  assign rdTs        = tsMem[headPtr];
  assign rdSrc       = srcMem[headPtr];
  assign rdSnap      = snapMem[headPtr];
  assign rdPtr       = headPtr;
  assign unreadCount = cnt;
  assign notEmpty    = (cnt != '0);
endmodule

// File: rtl/frl_top.sv
module frl_top
  import frl_pkg::*;
#(
  parameter int NSRC     = 7,
  parameter int TEL_W    = 12,
  parameter int NTEL     = 3,
  parameter int TS_W     = 16,
  parameter int DEPTH    = 8,
  parameter int OFF_W    = 12,
  parameter int RETRY_W  = 3,
  parameter int WDOG_IDX = 3,
  parameter int SRC_W    = $clog2(NSRC),
  parameter int SNAP_W   = NTEL * TEL_W,
  parameter int PTR_W    = $clog2(DEPTH),
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NSRC-1:0]    faultIn,
  input  logic [2*NSRC-1:0]  policyCfg,
  input  logic [OFF_W-1:0]   hiccupOff,
  input  logic [RETRY_W-1:0] retryLimit,
  input  logic [SNAP_W-1:0]  telemetry,
  input  logic               clearLatch,
  input  logic               alertAck,
  input  logic               rdPop,
  output logic               pwmEnable,
  output logic               derate,
  output logic               latched,
  output logic               alert,
  output logic [TS_W-1:0]    rdTs,
  output logic [SRC_W-1:0]   rdSrc,
  output logic [SNAP_W-1:0]  rdSnap,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [CNT_W-1:0]   unreadCount
);
  logStrobe_t       strobe;
  logic [SRC_W-1:0] srcCode;
  logic             logNotEmpty;

  frl_ctrl #(
    .NSRC(NSRC), .SRC_W(SRC_W), .OFF_W(OFF_W),
    .RETRY_W(RETRY_W), .WDOG_IDX(WDOG_IDX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .policyCfg(policyCfg),
    .hiccupOff(hiccupOff), .retryLimit(retryLimit), .clearLatch(clearLatch),
    .alertAck(alertAck), .rdPop(rdPop), .logNotEmpty(logNotEmpty),
    .strobe(strobe), .srcCode(srcCode), .pwmEnable(pwmEnable),
    .derate(derate), .latched(latched), .alert(alert)
  );

  frl_log #(
    .DEPTH(DEPTH), .TS_W(TS_W), .SRC_W(SRC_W), .SNAP_W(SNAP_W),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) i_log (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcCode(srcCode),
    .snapIn(telemetry), .rdTs(rdTs), .rdSrc(rdSrc), .rdSnap(rdSnap),
    .rdPtr(rdPtr), .unreadCount(unreadCount), .notEmpty(logNotEmpty)
  );
endmodule

// File: rtl/frl_chk.sv
module frl_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwmEnable,
  input logic             derate,
  input logic             latched,
  input logic             alert,
  input logic             alertAck,
  input logic             clearLatch,
  input logic [CNT_W-1:0] unreadCount
);
  // R12: latch-off keeps the stage disabled
  p_latch_blocks_pwm_r12: assert property (@(posedge clk) disable iff (!rstN)
    latched |-> !pwmEnable);

  // R12: only a clear releases the latch
  p_latch_holds_r12: assert property (@(posedge clk) disable iff (!rstN)
    latched && !clearLatch |=> latched);

  // R9: derate is only requested from a running stage
  p_derate_needs_pwm_r9: assert property (@(posedge clk) disable iff (!rstN)
    derate |-> pwmEnable);

  // R7: alert persists until acknowledged
  p_alert_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    alert && !alertAck |=> alert);

  // R5: unread records never exceed the ring depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    unreadCount <= CNT_W'(DEPTH));

  // R4: at most one record enters per cycle
  p_one_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (unreadCount == '0) |=> (unreadCount <= CNT_W'(1)));
endmodule

bind frl_top frl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .pwmEnable(pwmEnable), .derate(derate),
  .latched(latched), .alert(alert), .alertAck(alertAck),
  .clearLatch(clearLatch), .unreadCount(unreadCount)
);

// File: tb/test_frl_top.sv
module test_frl_top;
  localparam int NSRC = 7, SNAP_W = 36, DEPTH = 8;
  localparam int SC = 0, OV = 1, OC = 2, WD = 3, OT = 4, FAN = 5, COM = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NSRC-1:0] faultIn = '0;
  logic [2*NSRC-1:0] policyCfg;
  logic [11:0] hiccupOff = 12'd5;
  logic [2:0] retryLimit = 3'd2;
  logic [SNAP_W-1:0] telemetry = '0;
  logic clearLatch = 1'b0, alertAck = 1'b0, rdPop = 1'b0;
  logic pwmEnable, derate, latched, alert;
  logic [15:0] rdTs;
  logic [2:0] rdSrc;
  logic [SNAP_W-1:0] rdSnap;
  logic [2:0] rdPtr;
  logic [3:0] unreadCount;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  frl_top i_frl_top (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .policyCfg(policyCfg),
    .hiccupOff(hiccupOff), .retryLimit(retryLimit), .telemetry(telemetry),
    .clearLatch(clearLatch), .alertAck(alertAck), .rdPop(rdPop),
    .pwmEnable(pwmEnable), .derate(derate), .latched(latched), .alert(alert),
    .rdTs(rdTs), .rdSrc(rdSrc), .rdSnap(rdSnap), .rdPtr(rdPtr),
    .unreadCount(unreadCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setPolicy(input int idx, input int pol);
    policyCfg[2*idx +: 2] = 2'(pol);
  endtask

  task automatic defaultPolicies();
    setPolicy(SC, 3); setPolicy(OV, 3); setPolicy(OC, 2); setPolicy(WD, 3);
    setPolicy(OT, 0); setPolicy(FAN, 1); setPolicy(COM, 0);
  endtask

  task automatic popOne();
    rdPop = 1'b1; tick(); rdPop = 1'b0;
  endtask

  task automatic drain();
    while (unreadCount != 0) popOne();
    alertAck = 1'b1; tick(); alertAck = 1'b0;
  endtask

  task automatic t_reset();
    check(pwmEnable == 1, "R1", "pwmEnable", pwmEnable, 1);
    check(derate == 0, "R1", "derate", derate, 0);
    check(latched == 0, "R1", "latched", latched, 0);
    check(alert == 0, "R1", "alert", alert, 0);
    check(unreadCount == 0, "R1", "unreadCount", unreadCount, 0);
  endtask

  task automatic t_logContent();
    longint ts0;
    telemetry = 36'hABC_123_456;
    faultIn[FAN] = 1'b1; tick();
    check(unreadCount == 1, "R3", "count after fan", unreadCount, 1);
    check(alert == 1, "R7", "alert after write", alert, 1);
    check(pwmEnable == 0, "R8", "pwm during shutdown", pwmEnable, 0);
    check(rdSrc == FAN, "R3", "source code", rdSrc, FAN);
    check(rdSnap == 36'hABC_123_456, "R3", "snapshot", rdSnap, 36'hABC_123_456);
    ts0 = rdTs;
    telemetry = 36'h111_222_333;
    repeat (5) tick();
    check(unreadCount == 1, "R2", "held fault logged once", unreadCount, 1);
    faultIn[FAN] = 1'b0; tick();
    check(pwmEnable == 1, "R8", "pwm after shutdown clears", pwmEnable, 1);
    faultIn[COM] = 1'b1; tick();
    check(derate == 1, "R9", "derate on comm fault", derate, 1);
    check(unreadCount == 2, "R2", "second record", unreadCount, 2);
    popOne();
    check(rdSrc == COM, "R6", "head after pop", rdSrc, COM);
    check(rdTs == 16'(ts0 + 7), "R3", "timestamp spacing", rdTs, 16'(ts0 + 7));
    check(rdSnap == 36'h111_222_333, "R3", "second snapshot", rdSnap, 36'h111_222_333);
    alertAck = 1'b1; tick(); alertAck = 1'b0;
    check(alert == 0, "R7", "alert cleared by ack", alert, 0);
    faultIn[COM] = 1'b0; tick();
    check(derate == 0, "R9", "derate released", derate, 0);
    drain();
  endtask

  task automatic t_ackVsWrite();
    faultIn[OT] = 1'b1; tick();
    alertAck = 1'b1; faultIn[FAN] = 1'b1; tick(); alertAck = 1'b0;
    check(alert == 1, "R7", "write beats ack", alert, 1);
    check(derate == 0, "R9", "no derate while shut down", derate, 0);
    faultIn[FAN] = 1'b0; tick();
    check(derate == 1, "R9", "derate resumes", derate, 1);
    faultIn[OT] = 1'b0; tick();
    drain();
  endtask

  task automatic t_sameCycle();
    faultIn[COM] = 1'b1; faultIn[OT] = 1'b1; tick();
    check(unreadCount == 1, "R4", "first of pair", unreadCount, 1);
    tick();
    check(unreadCount == 2, "R4", "second of pair", unreadCount, 2);
    check(rdSrc == OT, "R4", "lower index first", rdSrc, OT);
    popOne();
    check(rdSrc == COM, "R4", "higher index second", rdSrc, COM);
    faultIn[COM] = 1'b0; faultIn[OT] = 1'b0; tick();
    drain();
  endtask

  task automatic t_hiccup();
    int lowCycles = 0;
    faultIn[OC] = 1'b1; tick(); faultIn[OC] = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (pwmEnable) break;
      lowCycles++;
      tick();
    end
    check(lowCycles == 5, "R10", "hiccup off cycles", lowCycles, 5);
    check(latched == 0, "R10", "no latch after one retry", latched, 0);
    repeat (12) tick();
    drain();
  endtask

  task automatic t_escalate();
    for (int p = 0; p < 3; p++) begin
      faultIn[OC] = 1'b1; tick(); faultIn[OC] = 1'b0;
      if (p == 1) check(latched == 0, "R11", "within retry budget", latched, 0);
      tick(); tick();
    end
    check(latched == 1, "R11", "escalated to latch", latched, 1);
    check(pwmEnable == 0, "R12", "pwm off when latched", pwmEnable, 0);
    repeat (10) tick();
    check(latched == 1, "R12", "latch persists", latched, 1);
    clearLatch = 1'b1; tick(); clearLatch = 1'b0;
    check(latched == 0, "R12", "latch cleared", latched, 0);
    check(pwmEnable == 1, "R12", "pwm after clear", pwmEnable, 1);
    drain();
  endtask

  task automatic t_watchdog();
    setPolicy(WD, 0);
    faultIn[WD] = 1'b1; tick(); faultIn[WD] = 1'b0;
    check(latched == 1, "R12", "watchdog always latches", latched, 1);
    check(derate == 0, "R12", "watchdog not a derate", derate, 0);
    clearLatch = 1'b1; tick(); clearLatch = 1'b0;
    check(pwmEnable == 1, "R12", "pwm after watchdog clear", pwmEnable, 1);
    defaultPolicies();
    drain();
  endtask

  task automatic t_severity();
    faultIn[SC] = 1'b1; faultIn[OC] = 1'b1; tick();
    faultIn[SC] = 1'b0; faultIn[OC] = 1'b0;
    check(latched == 1, "R13", "latch wins", latched, 1);
    tick();
    clearLatch = 1'b1; tick(); clearLatch = 1'b0;
    check(pwmEnable == 1, "R13", "no hiccup pending", pwmEnable, 1);
    check(unreadCount == 2, "R13", "both sources logged", unreadCount, 2);
    drain();
  endtask

  task automatic t_ring();
    popOne();
    check(unreadCount == 0, "R6", "pop on empty ignored", unreadCount, 0);
    for (int i = 0; i < DEPTH + 3; i++) begin
      telemetry = SNAP_W'(i);
      faultIn[COM] = 1'b1; tick(); faultIn[COM] = 1'b0; tick();
    end
    check(unreadCount == DEPTH, "R5", "count saturates", unreadCount, DEPTH);
    check(rdSnap == 3, "R5", "oldest survivor", rdSnap, 3);
    for (int i = 3; i < DEPTH + 3; i++) begin
      check(rdSnap == SNAP_W'(i), "R6", "ring order", rdSnap, i);
      popOne();
    end
    check(unreadCount == 0, "R6", "ring drained", unreadCount, 0);
  endtask

  initial begin
    defaultPolicies();
    fork
      begin
        repeat (3) tick();
        rstN = 1'b1; tick();
        t_reset();
        t_logContent();
        t_ackVsWrite();
        t_sameCycle();
        t_hiccup();
        t_escalate();
        t_watchdog();
        t_severity();
        t_ring();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule